// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer with Page-Table Walker

This block translates a virtual address into a physical address for the process that is running. It holds a small, fully associative set of page mappings. Each mapping stores a virtual page number, the physical page number it maps to, and the ID of the process that owns it. A lookup succeeds only when both the page number and the process ID match. Mappings left behind by another process are therefore skipped, and no flush is needed on a context switch.

When a lookup misses, the block reads one page-table entry from memory. The table has a single level and is indexed by virtual page number. The entry's address is a table base plus the page number times four. If the entry is valid, the block returns the physical address and installs the mapping. A free slot is used first; otherwise the least recently used slot is replaced. If the entry is invalid, the block raises a page fault and installs nothing.

The requester drives a request only while the block is idle and holds it until `done` is asserted. A flush input drops every cached mapping in one cycle.

Top module: `pid_tlb`

## Requirements
- R1: After reset, `done`, `hit`, `fault` and `mem_req` are low, and every slot is empty, so the first lookup of any address misses.
- R2: A request whose page number and process ID match a resident slot gives `done`=1 and `hit`=1 in the cycle after acceptance. In that case `paddr` = {cached physical page, address bits 11:0} and no memory read is issued.
- R3: A slot whose page number matches but whose process ID differs does not hit. Mappings of the same page for two processes can be resident together.
- R4: On a miss, `mem_req` rises in the cycle after acceptance, with `mem_addr` = `pt_base` + 4 × (address bits 31:12). Both stay unchanged until `mem_ack`.
- R5: A page-table entry is read as bit 31 = valid and bits 19:0 = physical page. When a valid entry is acknowledged, `done` follows one cycle later with `hit`=0, `fault`=0 and `paddr` = {entry bits 19:0, offset}. The mapping is installed, so a repeat of the same request hits.
- R6: When an invalid entry is acknowledged, `done` follows with `fault`=1 and `hit`=0. Nothing is installed, so a repeat walks memory again.
- R7: An install fills an empty slot if one exists. Otherwise it replaces the slot used least recently, where both hits and installs count as a use.
- R8: A cycle with `flush` high empties every slot. If `flush` coincides with the acknowledge of a valid entry, that entry is not installed either.
- R9: `done` is a single-cycle pulse, and a request is accepted only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| req_valid | input | 1 | Translation request, held until done |
| req_vaddr | input | 32 | Virtual address |
| req_pid | input | 4 | Current process ID |
| pt_base | input | 32 | Page-table base address |
| done | output | 1 | Result valid, one-cycle pulse |
| hit | output | 1 | Result came from a cached mapping |
| fault | output | 1 | Page-table entry was invalid |
| paddr | output | 32 | Physical address |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 32 | Page-table entry address |
| mem_ack | input | 1 | Read data valid, ends the read |
| mem_rdata | input | 32 | Page-table entry |

## Verification
The assertions assume the following about the environment:
- The requester keeps `req_vaddr` and `req_pid` stable from acceptance until `done`.
- `mem_ack` is raised only while `mem_req` is high, and only for one cycle.
- `mem_rdata` is valid in the cycle in which `mem_ack` is high.

The bench meets these assumptions in several ways. Its memory responder answers only a pending read and uses a latency of zero to three cycles, taken from the request address. It looks up the entry value with a formula computed from the page number. The requester task lowers its request on the cycle that `done` is seen.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 8,
  parameter int MA_W    = 32,
  parameter int MEM_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [MA_W-1:0]        pt_base,
  output logic                   done,
  output logic                   hit,
  output logic                   fault,
  output logic [PPN_W+OFF_W-1:0] paddr,
  output logic                   mem_req,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_ack,
  input  logic [MEM_W-1:0]       mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PTE_V = MEM_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} state_t;
  state_t state;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PID_W-1:0]   ent_pid [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [IDX_W-1:0]   age     [ENTRIES];

  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PID_W-1:0] pid_q;
  logic             hit_q, fault_q;
  logic [PA_W-1:0]  paddr_q;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_v[g] && ent_vpn[g] == req_vpn && ent_pid[g] == req_pid;
  end

  logic [IDX_W-1:0] hit_idx, vic;
  logic [PPN_W-1:0] hit_ppn;
  logic             found;
  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_ppn = ent_ppn[i];
      end
  end

  always_comb begin
    vic   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!ent_v[i] && !found) begin
        vic   = IDX_W'(i);
        found = 1'b1;
      end
    if (!found)
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == IDX_W'(ENTRIES - 1)) vic = IDX_W'(i);
  end

  wire accept    = state == S_IDLE && req_valid;
  wire any_hit   = |match && !flush;
  wire pte_ok    = mem_rdata[PTE_V];
  wire walk_end  = state == S_WALK && mem_ack;
  wire fill      = walk_end && pte_ok && !flush;
  wire touch     = (accept && any_hit) || fill;
  wire [IDX_W-1:0] touch_idx = fill ? vic : hit_idx;

  assign done     = state == S_DONE;
  assign hit      = done && hit_q;
  assign fault    = done && fault_q;
  assign paddr    = paddr_q;
  assign mem_req  = state == S_WALK;
  assign mem_addr = pt_base + (MA_W'(vpn_q) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ent_v   <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      pid_q   <= '0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          vpn_q <= req_vpn;
          off_q <= req_vaddr[OFF_W-1:0];
          pid_q <= req_pid;
          if (any_hit) begin
            state   <= S_DONE;
            hit_q   <= 1'b1;
            fault_q <= 1'b0;
            paddr_q <= {hit_ppn, req_vaddr[OFF_W-1:0]};
          end else begin
            state <= S_WALK;
          end
        end
        S_WALK: if (mem_ack) begin
          state   <= S_DONE;
          hit_q   <= 1'b0;
          fault_q <= !pte_ok;
          paddr_q <= pte_ok ? {mem_rdata[PPN_W-1:0], off_q} : '0;
        end
        default: state <= S_IDLE;
      endcase

      if (flush) ent_v <= '0;
      else if (fill) begin
        ent_v[vic]   <= 1'b1;
        ent_vpn[vic] <= vpn_q;
        ent_pid[vic] <= pid_q;
        ent_ppn[vic] <= mem_rdata[PPN_W-1:0];
      end

      if (touch)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
    end
  end

  p_unique_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> (hit && !mem_req));
  p_miss_walks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_hit) |=> mem_req);
  p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_fault_no_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_end && !pte_ok && !flush) |=> (fault && $stable(ent_v)));
  p_excl_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(hit && fault));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0));
endmodule

// File: tb/pid_tlb_bench.sv
module pid_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PT_BASE = 32'h0008_0000;

  logic clk = 0, rst_n = 0, flush_a = 0, flush_b = 0, req_valid = 0;
  logic [31:0] req_vaddr = '0, mem_rdata = '0, paddr, mem_addr, last_addr = '0;
  logic [3:0] req_pid = '0;
  logic done, hit, fault, mem_req, mem_ack = 0;
  logic flush_on_ack = 0;
  wire flush = flush_a | flush_b;
  int checks = 0, fails = 0, walks = 0, wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_tlb u_pid_tlb (.clk, .rst_n, .flush, .req_valid, .req_vaddr, .req_pid,
    .pt_base(PT_BASE), .done, .hit, .fault, .paddr, .mem_req, .mem_addr,
    .mem_ack, .mem_rdata);

  function automatic logic [19:0] ppn_of(logic [19:0] vpn);
    return 20'(vpn * 7 + 20'h123);
  endfunction
  function automatic logic pte_valid(logic [19:0] vpn);
    return vpn[3:0] != 4'hD;
  endfunction
  function automatic logic [31:0] exp_pa(logic [31:0] va);
    return {ppn_of(va[31:12]), va[11:0]};
  endfunction

  always @(negedge clk) begin
    flush_b = 0;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wait_cnt >= int'(mem_addr[3:2])) begin
        logic [19:0] v;
        v = 20'((mem_addr - PT_BASE) >> 2);
        mem_rdata = {pte_valid(v), 11'b0, ppn_of(v)};
        mem_ack = 1;
        last_addr = mem_addr;
        walks++;
        wait_cnt = 0;
        if (flush_on_ack) flush_b = 1;
      end else wait_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic [3:0] pid,
                       output logic h, output logic f, output logic [31:0] pa,
                       output int lat, output logic done_after);
    req_valid = 1; req_vaddr = va; req_pid = pid; lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 100);
    h = hit; f = fault; pa = paddr;
    req_valid = 0;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic do_flush();
    flush_a = 1; @(negedge clk); flush_a = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    logic h, f, da;
    logic [31:0] pa;
    int lat, w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !hit && !fault && !mem_req, "R1", "idle outputs after reset",
        {28'b0, done, hit, fault, mem_req}, 32'h0);

    w0 = walks;
    xlate(32'h0000_4ABC, 4'd3, h, f, pa, lat, da);
    chk(walks == w0 + 1, "R1", "first lookup walks", walks - w0, 1);
    chk(last_addr == PT_BASE + 32'h10, "R4", "entry address", last_addr, PT_BASE + 32'h10);
    chk(!h && !f && pa == exp_pa(32'h0000_4ABC), "R5", "walk result", pa, exp_pa(32'h0000_4ABC));
    chk(da == 0, "R9", "done is one pulse", {31'b0, da}, 0);

    w0 = walks;
    xlate(32'h0000_4ABC, 4'd3, h, f, pa, lat, da);
    chk(h && lat == 1 && walks == w0, "R2", "hit in one cycle", lat, 1);
    chk(pa == exp_pa(32'h0000_4ABC), "R2", "hit paddr", pa, exp_pa(32'h0000_4ABC));

    w0 = walks;
    xlate(32'h0000_4123, 4'd5, h, f, pa, lat, da);
    chk(!h && walks == w0 + 1, "R3", "other pid misses", {31'b0, h}, 0);
    xlate(32'h0000_4FFF, 4'd3, h, f, pa, lat, da);
    chk(h && pa == exp_pa(32'h0000_4FFF), "R3", "both pids resident", pa, exp_pa(32'h0000_4FFF));

    w0 = walks;
    xlate(32'h0000_D010, 4'd3, h, f, pa, lat, da);
    chk(f && !h, "R6", "invalid entry faults", {31'b0, f}, 1);
    xlate(32'h0000_D010, 4'd3, h, f, pa, lat, da);
    chk(f && walks == w0 + 2, "R6", "fault not installed", walks - w0, 2);

    repeat (4) @(negedge clk);
    chk(!mem_req && !done, "R9", "idle without request", {31'b0, mem_req}, 0);

    do_flush();
    w0 = walks;
    xlate(32'h0000_4ABC, 4'd3, h, f, pa, lat, da);
    chk(!h && walks == w0 + 1, "R8", "flush empties", {31'b0, h}, 0);

    do_flush();
    for (int k = 0; k < 8; k++) xlate(32'h0010_0000 + k * 32'h1000, 4'd1, h, f, pa, lat, da);
    w0 = walks;
    for (int k = 0; k < 8; k++) begin
      xlate(32'h0010_0000 + k * 32'h1000, 4'd1, h, f, pa, lat, da);
      chk(h, "R7", "empty slots filled first", {31'b0, h}, 1);
    end
    xlate(32'h0010_0000, 4'd1, h, f, pa, lat, da);
    xlate(32'h0010_8000, 4'd1, h, f, pa, lat, da);
    chk(!h && walks == w0 + 1, "R7", "ninth page walks", walks - w0, 1);
    xlate(32'h0010_0000, 4'd1, h, f, pa, lat, da);
    chk(h, "R7", "recently hit page kept", {31'b0, h}, 1);
    xlate(32'h0010_1000, 4'd1, h, f, pa, lat, da);
    chk(!h, "R7", "oldest page evicted", {31'b0, h}, 0);
    xlate(32'h0010_3000, 4'd1, h, f, pa, lat, da);
    chk(h, "R7", "younger page kept", {31'b0, h}, 1);
    xlate(32'h0010_2000, 4'd1, h, f, pa, lat, da);
    chk(!h, "R7", "next oldest evicted", {31'b0, h}, 0);

    flush_on_ack = 1;
    xlate(32'h0020_0000, 4'd2, h, f, pa, lat, da);
    flush_on_ack = 0;
    chk(!h && pa == exp_pa(32'h0020_0000), "R8", "walk result under flush", pa, exp_pa(32'h0020_0000));
    w0 = walks;
    xlate(32'h0020_0000, 4'd2, h, f, pa, lat, da);
    chk(!h && walks == w0 + 1, "R8", "flush beats install", {31'b0, h}, 0);

    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] va;
        va = {12'h0, 4'(p), 4'(k * 3), 12'(p * 97 + k * 13)};
        xlate(va, 4'(p), h, f, pa, lat, da);
        if (pte_valid(va[31:12])) begin
          chk(!h && !f && pa == exp_pa(va), "R5", "sweep miss", pa, exp_pa(va));
          xlate(va, 4'(p), h, f, pa, lat, da);
          chk(h && lat == 1 && pa == exp_pa(va), "R2", "sweep hit", pa, exp_pa(va));
        end else chk(f, "R6", "sweep fault", {31'b0, f}, 1);
      end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule